// File: doc/BRIEF.md
# Reduced Two-Domain Request/Acknowledge Controller

This block carries single control events from a requesting clock domain (A) to a responding clock domain (B) and returns a completion event to A. A parameter selects one of two reduced handshakes. In the level variant (`MODE = 0`), A drives a held request level. B answers with an acknowledge one clock wide, and B never waits for the request to fall. In the pulse variant (`MODE = 1`), the request and the acknowledge are both one-cycle pulses, and each side keeps a flag that records an outstanding transfer.

On the A side, a user raises `a_start` for a cycle and later sees `a_done` pulse once. `a_busy` shows that a transfer is in flight, and a new start is not taken while it is high. On the B side, `b_event` pulses once for each accepted start. No data is moved. A data bus that is held stable by the A side between `a_start` and `a_done` can be sampled by B on `b_event`.

Top module: `xdom_handshake`

## Requirements
- R1: While the domain resets are low (synchronous, active low), `a_busy`, `a_done` and `b_event` are 0.
- R2: `a_start` is accepted at an `a_clk` edge where `a_busy` is 0, and `a_busy` reads 1 from the next cycle.
- R3: `a_start` at an edge where `a_busy` is 1 is ignored: it yields no extra `b_event` and no extra `a_done`.
- R4: Each accepted start produces exactly one `b_event` pulse, one `b_clk` cycle wide.
- R5: Each accepted start produces exactly one `a_done` pulse, one `a_clk` cycle wide, and `a_done` is only high while `a_busy` is high.
- R6: With `MODE = 0`, the request is a level held from acceptance until the acknowledge arrives. It passes through a flop synchronizer, and the responder fires on its synchronized rising edge.
- R7: With `MODE = 0`, after the `a_done` cycle `a_busy` stays high for exactly `MIN_LOW` further `a_clk` cycles, so that the request stays low long enough for B to see the gap. `MIN_LOW` times the `a_clk` period must exceed the `b_clk` period.
- R8: With `MODE = 1`, request and acknowledge are single pulses carried by toggle synchronizers, with a pending flag on each side. `a_busy` is 0 in the cycle after `a_done`.
- R9: Over a run, the counts of accepted starts, `b_event` pulses and `a_done` pulses are equal when B is faster than A, equal in speed to A, or slower than A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Requester-domain clock |
| a_rst_n | input | 1 | Requester-domain synchronous reset, active low |
| a_start | input | 1 | One-cycle strobe that begins a transfer |
| a_busy | output | 1 | A transfer is outstanding; starts are ignored |
| a_done | output | 1 | One-cycle pulse when the acknowledge has returned |
| b_clk | input | 1 | Responder-domain clock |
| b_rst_n | input | 1 | Responder-domain synchronous reset, active low |
| b_event | output | 1 | One-cycle pulse per accepted request |

## Verification
The bench pushes starts into the exact cycle in which `a_done` is high and holds `a_start` high for long stretches. A design that let a start through while busy would show more events than accepted starts, or would lose one. With the responder clock slower than the requester clock, a level variant with a too-short low gap would merge two requests into one rising edge and hang. This shows up as a missing event and a wrong cool-down length. Runs with a fast responder expose a toggle synchronizer that emits double or stretched pulses through the one-cycle width checks on `b_event` and `a_done`.

// File: rtl/hs_pkg.sv
// Shared definitions for the reduced handshake controller.
// Assumes: MODE parameter values are taken from the constants below.
package hs_pkg;
    localparam int HS_MODE_LEVEL = 0;
    localparam int HS_MODE_PULSE = 1;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_HOLD = 2'd1,
        HS_COOL = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hs_sync_bit.sv
// Multi-flop synchronizer for one bit entering the clk domain.
// Assumes: d is a level that holds for longer than one clk period; STAGES >= 2.
module hs_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_level_xfer.sv
// Level synchronizer with a rising-edge detector: it turns a held level from
// another domain into a one-cycle pulse in dst_clk.
// Assumes: the level stays low for longer than one dst_clk period between rises.
module hs_level_xfer #(
    parameter int STAGES = 2
) (
    input  logic dst_clk,
    input  logic dst_rst_n,
    input  logic level_in,
    output logic rise_out
);
    logic synced;
    logic synced_d;

    hs_sync_bit #(.STAGES(STAGES)) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (level_in),
        .q     (synced)
    );

    // Remember last synchronized value for edge detection.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) synced_d <= 1'b0;
        else            synced_d <= synced;
    end

    assign rise_out = synced & ~synced_d;
endmodule

// File: rtl/hs_toggle_xfer.sv
// Toggle-based pulse synchronizer: each src pulse flips a level, and each
// synchronized flip becomes one dst pulse.
// Assumes: src pulses are spaced so that each flip is seen before the next one.
module hs_toggle_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic tog;
    logic synced;
    logic synced_d;

    // Flip the crossing level on every source pulse.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)     tog <= 1'b0;
        else if (src_pulse) tog <= ~tog;
    end

    hs_sync_bit #(.STAGES(STAGES)) u_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (tog),
        .q     (synced)
    );

    // Remember last synchronized level to detect a flip.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) synced_d <= 1'b0;
        else            synced_d <= synced;
    end

    assign dst_pulse = synced ^ synced_d;

    a_r4_dst_single: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);
endmodule

// File: rtl/xdom_handshake.sv
// Reduced request/acknowledge controller between clock domains A and B.
// MODE 0: held request level, one-cycle acknowledge, then a fixed low gap.
// MODE 1: pulse request and pulse acknowledge, with a pending flag per side.
// Assumes: for MODE 0, MIN_LOW a_clk periods exceed one b_clk period.
module xdom_handshake
    import hs_pkg::*;
#(
    parameter int MODE        = HS_MODE_LEVEL,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 4
) (
    input  logic a_clk,
    input  logic a_rst_n,
    input  logic a_start,
    output logic a_busy,
    output logic a_done,
    input  logic b_clk,
    input  logic b_rst_n,
    output logic b_event
);
    localparam int CW = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
    localparam logic [CW-1:0] COOL_LOAD = CW'(MIN_LOW - 1);

    hs_state_e   a_state;
    logic [CW-1:0] a_cnt;
    logic        a_accept;
    logic        a_ack;
    logic        b_fire;

    assign a_accept = a_start && (a_state == HS_IDLE);

    // Requester state: idle, waiting for acknowledge, request-low cool-down.
    always_ff @(posedge a_clk) begin
        if (!a_rst_n) begin
            a_state <= HS_IDLE;
            a_cnt   <= '0;
        end else begin
            case (a_state)
                HS_IDLE: if (a_accept) a_state <= HS_HOLD;
                HS_HOLD: if (a_ack) begin
                    if (MODE == HS_MODE_LEVEL) begin
                        a_state <= HS_COOL;
                        a_cnt   <= COOL_LOAD;
                    end else begin
                        a_state <= HS_IDLE;
                    end
                end
                HS_COOL: begin
                    if (a_cnt == '0) a_state <= HS_IDLE;
                    else             a_cnt   <= a_cnt - 1'b1;
                end
                default: a_state <= HS_IDLE;
            endcase
        end
    end

    assign a_busy  = (a_state != HS_IDLE);
    assign a_done  = a_ack && (a_state == HS_HOLD);
    assign b_event = b_fire;

    generate
        if (MODE == HS_MODE_LEVEL) begin : g_level
            logic a_req_q;

            // Hold the request level from acceptance until acknowledge.
            always_ff @(posedge a_clk) begin
                if (!a_rst_n)      a_req_q <= 1'b0;
                else if (a_accept) a_req_q <= 1'b1;
                else if (a_ack)    a_req_q <= 1'b0;
            end

            hs_level_xfer #(.STAGES(SYNC_STAGES)) u_req (
                .dst_clk   (b_clk),
                .dst_rst_n (b_rst_n),
                .level_in  (a_req_q),
                .rise_out  (b_fire)
            );

            a_r6_req_held: assert property (@(posedge a_clk) disable iff (!a_rst_n)
                (a_req_q && !a_ack) |=> a_req_q);
            a_r7_gap_after_done: assert property (@(posedge a_clk) disable iff (!a_rst_n)
                a_done |=> (a_busy && !a_req_q));
        end else begin : g_pulse
            logic b_req_pulse;
            logic b_pend;

            hs_toggle_xfer #(.STAGES(SYNC_STAGES)) u_req (
                .src_clk   (a_clk),
                .src_rst_n (a_rst_n),
                .src_pulse (a_accept),
                .dst_clk   (b_clk),
                .dst_rst_n (b_rst_n),
                .dst_pulse (b_req_pulse)
            );

            // Responder pending flag: set by an arriving request, cleared when served.
            always_ff @(posedge b_clk) begin
                if (!b_rst_n)         b_pend <= 1'b0;
                else if (b_req_pulse) b_pend <= 1'b1;
                else if (b_pend)      b_pend <= 1'b0;
            end

            assign b_fire = b_pend;

            a_r8_pending_held: assert property (@(posedge a_clk) disable iff (!a_rst_n)
                (a_busy && !a_done) |=> a_busy);
            a_r8_busy_drops: assert property (@(posedge a_clk) disable iff (!a_rst_n)
                a_done |=> !a_busy);
        end
    endgenerate

    hs_toggle_xfer #(.STAGES(SYNC_STAGES)) u_ack (
        .src_clk   (b_clk),
        .src_rst_n (b_rst_n),
        .src_pulse (b_fire),
        .dst_clk   (a_clk),
        .dst_rst_n (a_rst_n),
        .dst_pulse (a_ack)
    );

    a_r2_accept_sets_busy: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (a_start && !a_busy) |=> a_busy);
    a_r5_done_while_busy: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        a_done |-> a_busy);
    a_r5_done_single: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        a_done |=> !a_done);
    a_r4_event_single: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        b_event |=> !b_event);
endmodule

// File: tb/xdom_handshake_bench.sv
// Bench for both handshake variants at three responder clock ratios.
module xdom_handshake_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_CYCLES = 4;

    logic a_clk = 1'b0;
    logic b_clk = 1'b0;
    logic a_rst_n = 1'b0;
    logic b_rst_n = 1'b0;
    int   b_half = 5;

    logic [1:0] start = 2'b00;
    logic [1:0] busy;
    logic [1:0] done;
    logic [1:0] ev;

    int checks = 0;
    int errors = 0;
    int accepted [2];
    int dones    [2];
    int events   [2];
    int ignored  [2];
    logic ev_prev [2];

    always #(CLK_PERIOD/2) a_clk = ~a_clk;
    always #(b_half) b_clk = ~b_clk;

    xdom_handshake #(.MODE(0), .SYNC_STAGES(2), .MIN_LOW(GAP_CYCLES)) u_xdom_handshake (
        .a_clk(a_clk), .a_rst_n(a_rst_n), .a_start(start[0]), .a_busy(busy[0]),
        .a_done(done[0]), .b_clk(b_clk), .b_rst_n(b_rst_n), .b_event(ev[0]));

    xdom_handshake #(.MODE(1), .SYNC_STAGES(2), .MIN_LOW(GAP_CYCLES)) u_xdom_handshake_pulse (
        .a_clk(a_clk), .a_rst_n(a_rst_n), .a_start(start[1]), .a_busy(busy[1]),
        .a_done(done[1]), .b_clk(b_clk), .b_rst_n(b_rst_n), .b_event(ev[1]));

    // Expected busy cycles after the done cycle (R7 for level, R8 for pulse).
    function automatic int expected_gap(input int m);
        return (m == 0) ? GAP_CYCLES : 0;
    endfunction

    function automatic string tag_of_gap(input int m);
        return (m == 0) ? "R7" : "R8";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Count responder events and check one-cycle width (R4).
    always @(negedge b_clk) begin
        if (b_rst_n) begin
            for (int m = 0; m < 2; m++) begin
                if (ev[m]) begin
                    events[m]++;
                    check(!ev_prev[m], "R4 event width", 2, 1);
                end
                ev_prev[m] = ev[m];
            end
        end
    end

    bit   gap_on   [2];
    int   gap_len  [2];
    logic done_prev[2];

    // One a_clk cycle: observe outputs, then drive the next start values.
    task automatic step(input int mode_sel);
        bit want;
        @(negedge a_clk);
        for (int m = 0; m < 2; m++) begin
            if (done[m]) begin
                dones[m]++;
                check(!done_prev[m], "R5 done width", 2, 1);
                check(busy[m] == 1'b1, "R5 done while busy", int'(busy[m]), 1);
            end
            if (gap_on[m]) begin
                if (busy[m]) gap_len[m]++;
                else begin
                    check(gap_len[m] == expected_gap(m), tag_of_gap(m), gap_len[m], expected_gap(m));
                    gap_on[m] = 1'b0;
                end
            end
            if (done[m]) begin
                gap_on[m]  = 1'b1;
                gap_len[m] = 0;
            end
            done_prev[m] = done[m];
            case (mode_sel)
                0: want = ($urandom % 4) == 0;
                1: want = 1'b1;
                default: want = 1'b0;
            endcase
            start[m] = want;
            if (want && !busy[m]) accepted[m]++;   // R2: taken when not busy
            if (want && busy[m])  ignored[m]++;    // R3: must be dropped
        end
    endtask

    task automatic run_phase(input int half, input string label);
        b_half = half;
        for (int i = 0; i < 1500; i++) step(0);
        for (int i = 0; i < 300; i++)  step(1);
        for (int i = 0; i < 250; i++)  step(2);
        for (int m = 0; m < 2; m++) begin
            // R3/R4/R5/R9: ignored starts add nothing; counts match.
            check(events[m] == accepted[m], "R4 R9 events vs accepted", events[m], accepted[m]);
            check(dones[m] == accepted[m], "R5 R9 dones vs accepted", dones[m], accepted[m]);
            check(ignored[m] > 0, "R3 ignored starts exercised", ignored[m], 1);
            if (m == 0) check(events[m] > 0, "R6 level events seen", events[m], 1);
            else        check(events[m] > 0, "R8 pulse events seen", events[m], 1);
            check(busy[m] == 1'b0, "R9 idle after drain", int'(busy[m]), 0);
        end
        $display("phase %s: level %0d/%0d/%0d pulse %0d/%0d/%0d", label,
                 accepted[0], events[0], dones[0], accepted[1], events[1], dones[1]);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int m = 0; m < 2; m++) begin
            accepted[m] = 0; dones[m] = 0; events[m] = 0; ignored[m] = 0;
            ev_prev[m] = 1'b0; gap_on[m] = 1'b0; gap_len[m] = 0; done_prev[m] = 1'b0;
        end
        start = 2'b11;   // starts during reset must have no effect
        repeat (4) @(negedge a_clk);
        for (int m = 0; m < 2; m++) begin
            check(busy[m] == 1'b0, "R1 busy in reset", int'(busy[m]), 0);
            check(done[m] == 1'b0, "R1 done in reset", int'(done[m]), 0);
            check(ev[m] == 1'b0, "R1 event in reset", int'(ev[m]), 0);
        end
        start = 2'b00;
        a_rst_n = 1'b1;
        b_rst_n = 1'b1;
        @(negedge a_clk);
        // R2 directed: single start from idle raises busy on the next cycle.
        start = 2'b11;
        accepted[0]++; accepted[1]++;
        @(negedge a_clk);
        start = 2'b00;
        check(busy == 2'b11, "R2 busy after accept", int'(busy), 3);
        run_phase(5, "equal");
        run_phase(2, "fast-b");
        run_phase(13, "slow-b");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule